// File: doc/BRIEF.md
# Dual Countdown Timer With Interrupts

This peripheral holds two identical countdown channels behind a 32-bit word-access register bus. Each channel has a divisor register, a read-only count and a control register. A two-bit operation field in the control register loads the divisor into the counter, holds the counter, or lets it run. A rate field picks which of four external tick-enable inputs makes the counter step. When a running counter finishes a period it reloads from its divisor and sets that channel's pending bit.

The pending bits feed a shared interrupt unit with a read/write mask and a write-ones-to-clear acknowledge register. The single `irq` output is high while any pending bit is also unmasked. A free-running time register counts the fastest tick enable, which stands for 10 ns, so it reads in units of 10 ns. Clock generation and bus bridging sit outside the block. Reads are combinational, so read data is valid in the same cycle as the address. Writes take effect at the next rising clock edge.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset, the divisor, count and control registers of both channels, the mask, the pending bits and the time register all read zero, and `irq` is low.
- R2: Byte offsets 0x00, 0x04 and 0x08 hold the channel-0 divisor, count and control registers; 0x10, 0x14 and 0x18 hold the same registers for channel 1. Writing control with operation bits [1:0] = 0 (load) copies the divisor into the count and leaves the channel stopped.
- R3: With operation 2 (run), the count decrements by one on each cycle in which the selected tick enable is high. With operation 1 (hold), the count does not change.
- R4: Control bits [4:2] form the rate code. Codes 4, 5, 6 and 7 select `tick_en[0]`, `tick_en[1]`, `tick_en[2]` and `tick_en[3]`. Codes 0 to 3 (external or disabled clock) select no tick, so the count stays frozen.
- R5: When a selected tick arrives while a running count is 1 or 0, the count reloads from the divisor, and the pending bit of that channel is set: bit 0 for channel 0 and bit 1 for channel 1.
- R6: Offset 0x48 is the read/write mask (bits [1:0]). Offset 0x50 reads the raw pending bits. Offset 0x54 reads the pending bits ANDed with the mask. `irq` is the OR of those masked bits.
- R7: A write to 0x4C clears each pending bit whose data bit is one. If an expiry arrives in the same cycle as the acknowledge, the expiry wins and the bit stays set.
- R8: Offset 0x38 reads a 32-bit time value that increments by one on every cycle in which `tick_en[3]` is high.
- R9: A control write with operation 3 is ignored. The control register and the count keep their previous values.
- R10: Reads from unmapped or non-word-aligned offsets return zero. Writes to those offsets, and to the read-only count, raw, masked and time offsets, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| tick_en | input | 4 | Tick enables for rate codes 4 to 7; bit 3 also drives the time register |
| irq | output | 1 | High while any unmasked pending bit is set |

## Verification
The bench targets the period boundary: after a three-tick period the count must show the reload value rather than zero. An off-by-one in the reload compare would shift the expiry by one tick, or leave the count at zero. It drives an acknowledge in the same cycle as an expiry. A design that gave clearing priority there would drop an event and leave `irq` low. It also pulses non-selected tick enables, sets a disabled rate code and writes an illegal operation code. A design with a wrong rate decode, or one that accepted operation 3, would move the count or change the control read-back. Finally it writes to read-only and unmapped offsets and checks that the mask, the count and the read data stay unchanged.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } dct_op_e;

  localparam int CH_STRIDE  = 'h10;
  localparam int OFF_DIV    = 'h00;
  localparam int OFF_CNT    = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_TIME   = 'h38;
  localparam int OFF_MASK   = 'h48;
  localparam int OFF_ACK    = 'h4C;
  localparam int OFF_RAW    = 'h50;
  localparam int OFF_MASKED = 'h54;
  localparam int RATE_BASE  = 4;
endpackage

// File: rtl/dct_channel.sv
module dct_channel
  import dct_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NRATE  = 4,
  parameter int CTRL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_we,
  input  logic              ctrl_we,
  input  logic [DW-1:0]     wdata,
  input  logic [NRATE-1:0]  tick_en,
  output logic [DW-1:0]     div_q,
  output logic [DW-1:0]     count_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              running,
  output logic              expire
);
  localparam int RATE_W = CTRL_W - 2;

  logic [DW-1:0]     div_d, count_d;
  logic [CTRL_W-1:0] ctrl_d;
  logic [RATE_W-1:0] rate;
  dct_op_e           op_wr;
  logic              ctrl_take, sel_tick, step;

  assign op_wr     = dct_op_e'(wdata[1:0]);
  assign ctrl_take = ctrl_we && (op_wr != OP_BAD);
  assign rate      = ctrl_q[CTRL_W-1:2];
  assign running   = (dct_op_e'(ctrl_q[1:0]) == OP_RUN);

  // rate code -> tick enable; codes below RATE_BASE pick nothing
  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < NRATE; i++) begin
      if (rate == RATE_W'(RATE_BASE + i)) sel_tick = tick_en[i];
    end
  end

  assign step   = running && sel_tick && !ctrl_take;
  assign expire = step && (count_q <= DW'(1));

  always_comb begin
    div_d   = div_we ? wdata : div_q;
    ctrl_d  = ctrl_take ? wdata[CTRL_W-1:0] : ctrl_q;
    count_d = count_q;
    if (ctrl_take && op_wr == OP_LOAD) begin
      count_d = div_q;
    end else if (expire) begin
      count_d = div_q;
    end else if (step) begin
      count_d = count_q - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      ctrl_q  <= '0;
      count_q <= '0;
    end else begin
      div_q   <= div_d;
      ctrl_q  <= ctrl_d;
      count_q <= count_d;
    end
  end
endmodule

// File: rtl/dct_irq_unit.sv
module dct_irq_unit #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mask_we,
  input  logic           ack_we,
  input  logic [NCH-1:0] wbits,
  input  logic [NCH-1:0] expire,
  output logic [NCH-1:0] pend_q,
  output logic [NCH-1:0] mask_q,
  output logic           irq
);
  logic [NCH-1:0] pend_d, mask_d, clr;

  assign clr = ack_we ? wbits : '0;

  always_comb begin
    mask_d = mask_we ? wbits : mask_q;
    pend_d = (pend_q & ~clr) | expire;   // a new expiry beats a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  assign irq = |(pend_q & mask_q);
endmodule

// File: rtl/dct_timebase.sv
module dct_timebase #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [TW-1:0] time_q
);
  logic [TW-1:0] time_d;

  assign time_d = tick ? time_q + TW'(1) : time_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_d;
  end
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
  import dct_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 8,
  parameter int NCH    = 2,
  parameter int NRATE  = 4,
  parameter int CTRL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NRATE-1:0] tick_en,
  output logic             irq
);
  localparam int TIME_TICK = NRATE - 1;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic                         wr_en;
  logic [NCH-1:0]               div_we, ctrl_we, ch_run, ch_expire;
  logic [NCH-1:0][DW-1:0]       ch_div, ch_count;
  logic [NCH-1:0][CTRL_W-1:0]   ch_ctrl;
  logic [NCH-1:0]               pend_q, mask_q;
  logic [DW-1:0]                time_q;
  logic                         mask_we, ack_we;

  assign wr_en   = bus_sel && bus_wr;
  assign mask_we = wr_en && (bus_addr == AW'(OFF_MASK));
  assign ack_we  = wr_en && (bus_addr == AW'(OFF_ACK));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign div_we[c]  = wr_en && (bus_addr == AW'(c * CH_STRIDE + OFF_DIV));
    assign ctrl_we[c] = wr_en && (bus_addr == AW'(c * CH_STRIDE + OFF_CTRL));

    dct_channel #(.DW(DW), .NRATE(NRATE), .CTRL_W(CTRL_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .div_we  (div_we[c]),
      .ctrl_we (ctrl_we[c]),
      .wdata   (bus_wdata),
      .tick_en (tick_en),
      .div_q   (ch_div[c]),
      .count_q (ch_count[c]),
      .ctrl_q  (ch_ctrl[c]),
      .running (ch_run[c]),
      .expire  (ch_expire[c])
    );
  end

  dct_irq_unit #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mask_we (mask_we),
    .ack_we  (ack_we),
    .wbits   (bus_wdata[NCH-1:0]),
    .expire  (ch_expire),
    .pend_q  (pend_q),
    .mask_q  (mask_q),
    .irq     (irq)
  );

  dct_timebase #(.TW(DW)) u_time (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick_en[TIME_TICK]),
    .time_q (time_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      for (int c = 0; c < NCH; c++) begin
        if (bus_addr == AW'(c * CH_STRIDE + OFF_DIV))  bus_rdata = ch_div[c];
        if (bus_addr == AW'(c * CH_STRIDE + OFF_CNT))  bus_rdata = ch_count[c];
        if (bus_addr == AW'(c * CH_STRIDE + OFF_CTRL)) bus_rdata = DW'(ch_ctrl[c]);
      end
      if (bus_addr == AW'(OFF_TIME))   bus_rdata = time_q;
      if (bus_addr == AW'(OFF_MASK))   bus_rdata = DW'(mask_q);
      if (bus_addr == AW'(OFF_RAW))    bus_rdata = DW'(pend_q);
      if (bus_addr == AW'(OFF_MASKED)) bus_rdata = DW'(pend_q & mask_q);
    end
  end
endmodule

// File: rtl/dct_checker.sv
module dct_checker
  import dct_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int NCH   = 2,
  parameter int NRATE = 4
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic                   bus_sel,
  input logic                   bus_wr,
  input logic [AW-1:0]          bus_addr,
  input logic [DW-1:0]          bus_wdata,
  input logic [DW-1:0]          bus_rdata,
  input logic [NRATE-1:0]       tick_en,
  input logic                   irq,
  input logic [NCH-1:0][DW-1:0] ch_count,
  input logic [NCH-1:0]         ch_run,
  input logic [NCH-1:0]         ch_expire,
  input logic [NCH-1:0]         pend_q,
  input logic [DW-1:0]          time_q
);
  logic rd_en, ack_wr;
  assign rd_en  = bus_sel && !bus_wr;
  assign ack_wr = bus_sel && bus_wr && (bus_addr == AW'(OFF_ACK));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic ctrl_wr;
    assign ctrl_wr = bus_sel && bus_wr && (bus_addr == AW'(c * CH_STRIDE + OFF_CTRL));

    // R3: a stopped channel keeps its count unless its control is written
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!ch_run[c] && !ctrl_wr) |=> $stable(ch_count[c]));

    // R5: expiry lands in the pending bit of the same channel
    a_r5_expire_pends: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ch_expire[c] |=> pend_q[c]);

    // R7: acknowledge without a concurrent expiry clears the bit
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (ack_wr && bus_wdata[c] && !ch_expire[c]) |=> !pend_q[c]);
  end

  // R6: irq agrees with the masked read-back
  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && bus_addr == AW'(OFF_MASKED)) |-> (irq == (bus_rdata != '0)));

  // R8: time advances by one per fastest tick
  a_r8_time_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tick_en[NRATE-1] |=> (time_q == $past(time_q) + DW'(1)));

  // R10: misaligned reads return zero
  a_r10_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));
endmodule

bind dual_countdown_timer dct_checker #(
  .DW(DW), .AW(AW), .NCH(NCH), .NRATE(NRATE)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .tick_en    (tick_en),
  .irq        (irq),
  .ch_count   (ch_count),
  .ch_run     (ch_run),
  .ch_expire  (ch_expire),
  .pend_q     (pend_q),
  .time_q     (time_q)
);

// File: tb/sim_dual_countdown_timer.sv
module sim_dual_countdown_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  tick_en;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  dual_countdown_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] d, input logic [3:0] t);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = t;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_en = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
    #1;
  endtask

  task automatic tick(input logic [3:0] t);
    @(negedge clk);
    tick_en = t;
    @(negedge clk);
    tick_en = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 div0", v, 0);
    rd(8'h04, v); chk("R1 cnt0", v, 0);
    rd(8'h18, v); chk("R1 ctrl1", v, 0);
    rd(8'h48, v); chk("R1 mask", v, 0);
    rd(8'h50, v); chk("R1 pend", v, 0);
    rd(8'h38, v); chk("R1 time", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_period();
    logic [31:0] v;
    wr(8'h00, 3);
    wr(8'h08, 32'h10);               // rate 4, load
    rd(8'h04, v); chk("R2 load", v, 3);
    tick(4'b0001);
    rd(8'h04, v); chk("R2 stopped after load", v, 3);
    wr(8'h08, 32'h12);               // rate 4, run
    tick(4'b0001);
    rd(8'h04, v); chk("R3 run step", v, 2);
    tick(4'b0001);
    rd(8'h04, v); chk("R3 run step2", v, 1);
    rd(8'h50, v); chk("R5 not yet", v, 0);
    tick(4'b0001);
    rd(8'h04, v); chk("R5 reload", v, 3);
    rd(8'h50, v); chk("R5 pend0", v, 1);
  endtask

  task automatic t_irq_ack();
    logic [31:0] v;
    rd(8'h54, v); chk("R6 masked off", v, 0);
    chk("R6 irq masked", irq, 0);
    wr(8'h48, 1);
    rd(8'h48, v); chk("R6 mask rd", v, 1);
    rd(8'h54, v); chk("R6 masked on", v, 1);
    chk("R6 irq on", irq, 1);
    wr(8'h4C, 1);
    rd(8'h50, v); chk("R7 ack clr", v, 0);
    chk("R7 irq low", irq, 0);
  endtask

  task automatic t_hold_rate();
    logic [31:0] v;
    wr(8'h08, 32'h11);               // rate 4, hold
    tick(4'b0001);
    rd(8'h04, v); chk("R3 hold", v, 3);
    wr(8'h08, 32'h16);               // rate 5, run
    tick(4'b0101);
    rd(8'h04, v); chk("R4 other ticks", v, 3);
    tick(4'b0010);
    rd(8'h04, v); chk("R4 rate5", v, 2);
    wr(8'h08, 32'h02);               // rate 0, run
    tick(4'b0111);
    rd(8'h04, v); chk("R4 rate0 frozen", v, 2);
  endtask

  task automatic t_illegal();
    logic [31:0] v;
    wr(8'h08, 32'h11);
    wr(8'h08, 32'h13);               // op 3
    rd(8'h08, v); chk("R9 ctrl kept", v, 32'h11);
    rd(8'h04, v); chk("R9 count kept", v, 2);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    wr(8'h00, 1);
    wr(8'h08, 32'h10);
    wr(8'h08, 32'h12);
    tick(4'b0001);
    rd(8'h50, v); chk("R5 div1 pend", v, 1);
    wr_tick(8'h4C, 1, 4'b0001);
    rd(8'h50, v); chk("R7 expiry wins", v, 1);
    wr(8'h08, 32'h11);
    wr(8'h4C, 1);
    rd(8'h50, v); chk("R7 clr after hold", v, 0);
  endtask

  task automatic t_ch1_time();
    logic [31:0] v, t0;
    rd(8'h38, t0);
    wr(8'h10, 2);
    wr(8'h18, 32'h1C);               // rate 7, load
    wr(8'h18, 32'h1E);               // rate 7, run
    tick(4'b1000);
    rd(8'h14, v); chk("R3 ch1 step", v, 1);
    tick(4'b1000);
    rd(8'h50, v); chk("R5 pend1", v, 2);
    rd(8'h14, v); chk("R5 ch1 reload", v, 2);
    tick(4'b1000);
    rd(8'h38, v); chk("R8 time", v, t0 + 3);
    wr(8'h18, 32'h1D);
    wr(8'h4C, 2);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); chk("R10 unmapped rd", v, 0);
    rd(8'h0C, v); chk("R10 gap rd", v, 0);
    rd(8'h49, v); chk("R10 misaligned", v, 0);
    wr(8'h04, 32'h55);
    rd(8'h04, v); chk("R10 count ro", v, 1);
    wr(8'h54, 32'h3);
    rd(8'h48, v); chk("R10 mask untouched", v, 1);
    rd(8'h50, v); chk("R10 pend untouched", v, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; tick_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_period();
    t_irq_ack();
    t_hold_rate();
    t_illegal();
    t_same_cycle();
    t_ch1_time();
    t_unmapped();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule